// File: doc/BRIEF.md
# Squared-Error Fitness Accumulator

This block scores one run of a network under evolution. The network computes elsewhere and presents one output sample per tick with a valid strobe. The block adds up, sample by sample, the squared difference between that output and a target value, so a lower sum means a fitter network. The lower sum is compared against a loaded threshold with no division. When the last sample of the run has been taken, the block raises a one-cycle completion pulse. It also flags whether the final sum is at or below the threshold, which tells the search to stop.

The target schedule comes from values loaded with the start pulse, so one circuit scores different tasks without being rebuilt. In constant mode every tick is compared with one loaded value. In classification mode the run is split into examples. All positive examples come first and all negative examples follow. Each example lasts the same loaded number of ticks. The target is +0.8 during positive examples and -0.8 during negative ones. The block exports the current example index and the tick within that example, so upstream logic can apply the input vector that matches the expected sample.

Top module: `fit_score`

## Requirements
- R1: After reset, `sum_o` is 0, `done_o`, `hit_o` and `busy_o` are 0, and `ex_idx_o` and `tick_idx_o` are 0.
- R2: A `start_i` pulse has priority over any sample in the same cycle. It latches mode (`mode_i` 0 = constant, 1 = classification), constant target, example counts, ticks per example and threshold. In the next cycle `sum_o` is 0, `hit_o` is 0, both indices are 0, and `busy_o` is 1 unless the run is empty.
- R3: In constant mode, each accepted sample adds (sample - latched target)^2 to `sum_o`. Sample and target are signed two's complement with SW bits, read as fixed point with FB fraction bits. With the default SW=8 and FB=6, the value .1001 (0.5625) is code 36.
- R4: In classification mode, the target is +TGT and ex_idx < positive count, and -TGT afterwards. TGT is round(0.8 * 2^FB), which is 51 for FB=6.
- R5: A run accepts exactly ticks_per_example * (positives + negatives) samples. Before each accepted sample, `tick_idx_o` counts 0 up to ticks_per_example-1 and then wraps to 0 while `ex_idx_o` increments. Only cycles with `valid_i` high while busy advance the indices.
- R6: `done_o` is high for exactly one cycle: the cycle after the clock edge that takes the last sample. In that cycle `sum_o` holds the final sum, `busy_o` is 0 and both indices are back at 0.
- R7: `hit_o` equals (final sum <= threshold), compared unsigned. It is valid from the `done_o` cycle and held until the next start.
- R8: `valid_i` while not busy, and any `smp_i` value while `valid_i` is low, leave `sum_o` and both indices unchanged.
- R9: A run with zero ticks per example or zero total examples completes at once. `done_o` pulses in the cycle after start with `sum_o` = 0 and `hit_o` = 1.
- R10: The accumulator cannot overflow for any legal run. Its width is 2*SW+2+CW+EW+1 bits, and a run of 65535 worst-case errors (diff 255 at SW=8) gives the exact sum.
- R11: A start pulse during a run abandons that run. The new run's final sum contains only its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run and latch its settings |
| mode_i | input | 1 | 0 constant target, 1 classification schedule |
| tgt_i | input | SW | Constant-mode target, signed fixed point |
| npos_i | input | EW | Number of positive examples |
| nneg_i | input | EW | Number of negative examples |
| tpe_i | input | CW | Ticks per example |
| cutoff_i | input | AW | Stop threshold on the error sum |
| valid_i | input | 1 | Network output sample is present |
| smp_i | input | SW | Network output sample, signed fixed point |
| busy_o | output | 1 | Run in progress |
| ex_idx_o | output | EW+1 | Example index of the next expected sample |
| tick_idx_o | output | CW | Tick within the example of the next expected sample |
| sum_o | output | AW | Accumulated squared error |
| done_o | output | 1 | One-cycle run completion pulse |
| hit_o | output | 1 | Final sum is at or below the threshold |

## Verification
The bench uses the default widths: 8-bit samples with 6 fraction bits, 16-bit tick counts and 8-bit example counts. At these widths the squared error of every possible sample value against a constant target can be covered in one 256-tick run. It also sweeps the classification schedule over every combination of 0 to 3 positives, 0 to 3 negatives and 1 to 3 ticks per example. This covers empty runs, runs with only positive or only negative examples, and the wrap points of both index counters. A 65535-tick run at the largest possible error exercises the accumulator width. Samples arrive with idle gaps, and thresholds are set to exactly the final sum and to one below it.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic {
    MODE_CONST = 1'b0,
    MODE_CLASS = 1'b1
  } fit_mode_e;
endpackage

// File: rtl/fit_sched.sv
// Run sequencer: tracks tick and example position and flags the last sample.
module fit_sched #(
  parameter int CW = 16,
  parameter int EW = 8,
  localparam int XW = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [EW-1:0] npos_i,
  input  logic [EW-1:0] nneg_i,
  input  logic [CW-1:0] tpe_i,
  output logic          run_o,
  output logic          step_o,
  output logic          last_o,
  output logic          empty_o,
  output logic          pos_o,
  output logic [CW-1:0] tick_o,
  output logic [XW-1:0] ex_o
);
  logic          run_q, run_d;
  logic [CW-1:0] tick_q, tick_d, tpe_q, tpe_d;
  logic [XW-1:0] ex_q, ex_d, tot_q, tot_d;
  logic [EW-1:0] npos_q, npos_d;
  logic [XW-1:0] tot_in;
  logic          nonzero;
  logic          tick_end;
  logic          upd;

  assign tot_in   = {1'b0, npos_i} + {1'b0, nneg_i};
  assign nonzero  = (tot_in != '0) && (tpe_i != '0);
  assign step_o   = run_q && valid_i && !start_i;
  assign tick_end = (tick_q == tpe_q - CW'(1));
  assign last_o   = step_o && tick_end && (ex_q == tot_q - XW'(1));
  assign empty_o  = start_i && !nonzero;
  assign pos_o    = (ex_q < {1'b0, npos_q});
  assign upd      = start_i || step_o;

  always_comb begin
    run_d  = run_q;
    tick_d = tick_q;
    ex_d   = ex_q;
    tpe_d  = tpe_q;
    tot_d  = tot_q;
    npos_d = npos_q;
    if (start_i) begin
      run_d  = nonzero;
      tick_d = '0;
      ex_d   = '0;
      tpe_d  = tpe_i;
      tot_d  = tot_in;
      npos_d = npos_i;
    end else if (step_o) begin
      if (last_o) begin
        run_d  = 1'b0;
        tick_d = '0;
        ex_d   = '0;
      end else if (tick_end) begin
        tick_d = '0;
        ex_d   = ex_q + XW'(1);
      end else begin
        tick_d = tick_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      ex_q   <= '0;
      tpe_q  <= '0;
      tot_q  <= '0;
      npos_q <= '0;
    end else if (upd) begin
      run_q  <= run_d;
      tick_q <= tick_d;
      ex_q   <= ex_d;
      tpe_q  <= tpe_d;
      tot_q  <= tot_d;
      npos_q <= npos_d;
    end
  end

  assign run_o  = run_q;
  assign tick_o = tick_q;
  assign ex_o   = ex_q;

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tick_q < tpe_q)) else $error("tick index out of range"); // R5
  AST_EX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ex_q < tot_q)) else $error("example index out of range"); // R5
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> (!run_q && tick_q == '0 && ex_q == '0)) else $error("run did not end"); // R6
  AST_IDLE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> ($stable(tick_q) && $stable(ex_q))) else $error("index moved while idle"); // R8
endmodule

// File: rtl/fit_sqerr.sv
// Target selection and squared difference, purely combinational.
module fit_sqerr #(
  parameter int SW = 8,
  parameter int TGT_HI = 51,
  localparam int PW = 2 * SW + 2
) (
  input  fit_pkg::fit_mode_e mode_i,
  input  logic signed [SW-1:0] cst_i,
  input  logic                 pos_i,
  input  logic signed [SW-1:0] smp_i,
  output logic [PW-1:0]        sq_o
);
  localparam logic signed [SW:0] HI_C = (SW+1)'(TGT_HI);
  localparam logic signed [SW:0] LO_C = -HI_C;

  logic signed [SW:0] tgt_w;
  logic signed [SW:0] diff;
  logic [SW:0]        mag;

  always_comb begin
    if (mode_i == fit_pkg::MODE_CONST) tgt_w = {cst_i[SW-1], cst_i};
    else if (pos_i)                    tgt_w = HI_C;
    else                               tgt_w = LO_C;
    diff = {smp_i[SW-1], smp_i} - tgt_w;
    mag  = diff[SW] ? (SW+1)'(-diff) : (SW+1)'(diff);
    sq_o = PW'(mag) * PW'(mag);
  end
endmodule

// File: rtl/fit_acc.sv
// Error accumulator, completion pulse and threshold flag.
module fit_acc #(
  parameter int PW = 18,
  parameter int AW = 43
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic          empty_i,
  input  logic [PW-1:0] sq_i,
  input  logic [AW-1:0] cut_i,
  output logic [AW-1:0] sum_o,
  output logic          done_o,
  output logic          hit_o
);
  logic [AW-1:0] sum_q, sum_d, cut_q, cut_d;
  logic          done_q, done_d, hit_q, hit_d;

  always_comb begin
    sum_d  = sum_q;
    cut_d  = cut_q;
    hit_d  = hit_q;
    done_d = 1'b0;
    if (start_i) begin
      sum_d  = '0;
      cut_d  = cut_i;
      hit_d  = empty_i;
      done_d = empty_i;
    end else if (step_i) begin
      sum_d = sum_q + AW'(sq_i);
      if (last_i) begin
        done_d = 1'b1;
        hit_d  = (sum_d <= cut_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cut_q  <= '0;
      hit_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start_i || step_i) begin
        sum_q <= sum_d;
        cut_q <= cut_d;
        hit_q <= hit_d;
      end
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;
  assign hit_o  = hit_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !start_i) |=> (sum_q >= $past(sum_q))) else $error("accumulator wrapped"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> !done_q) else $error("done longer than one cycle"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !start_i) |=> $stable(sum_q)) else $error("sum moved without a sample"); // R8
  AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (hit_q == (sum_q <= cut_q))) else $error("threshold flag mismatch"); // R7
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !empty_i) |=> (sum_q == '0 && !hit_q)) else $error("start did not clear"); // R2
endmodule

// File: rtl/fit_score.sv
// Top: latches run settings and connects sequencer, error path and accumulator.
module fit_score #(
  parameter int SW = 8,
  parameter int FB = 6,
  parameter int CW = 16,
  parameter int EW = 8,
  localparam int XW = EW + 1,
  localparam int PW = 2 * SW + 2,
  localparam int AW = PW + CW + EW + 1,
  localparam int TGT_HI = (4 * (1 << FB) + 2) / 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [SW-1:0] tgt_i,
  input  logic [EW-1:0] npos_i,
  input  logic [EW-1:0] nneg_i,
  input  logic [CW-1:0] tpe_i,
  input  logic [AW-1:0] cutoff_i,
  input  logic          valid_i,
  input  logic [SW-1:0] smp_i,
  output logic          busy_o,
  output logic [XW-1:0] ex_idx_o,
  output logic [CW-1:0] tick_idx_o,
  output logic [AW-1:0] sum_o,
  output logic          done_o,
  output logic          hit_o
);
  fit_pkg::fit_mode_e mode_q, mode_d;
  logic [SW-1:0]      cst_q, cst_d;
  logic               step, last, empty, pos;
  logic [PW-1:0]      sq;

  always_comb begin
    mode_d = mode_q;
    cst_d  = cst_q;
    if (start_i) begin
      mode_d = fit_pkg::fit_mode_e'(mode_i);
      cst_d  = tgt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= fit_pkg::MODE_CONST;
      cst_q  <= '0;
    end else if (start_i) begin
      mode_q <= mode_d;
      cst_q  <= cst_d;
    end
  end

  fit_sched #(.CW(CW), .EW(EW)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .npos_i  (npos_i),
    .nneg_i  (nneg_i),
    .tpe_i   (tpe_i),
    .run_o   (busy_o),
    .step_o  (step),
    .last_o  (last),
    .empty_o (empty),
    .pos_o   (pos),
    .tick_o  (tick_idx_o),
    .ex_o    (ex_idx_o)
  );

  fit_sqerr #(.SW(SW), .TGT_HI(TGT_HI)) u_sqerr (
    .mode_i (mode_q),
    .cst_i  (cst_q),
    .pos_i  (pos),
    .smp_i  (smp_i),
    .sq_o   (sq)
  );

  fit_acc #(.PW(PW), .AW(AW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .step_i  (step),
    .last_i  (last),
    .empty_i (empty),
    .sq_i    (sq),
    .cut_i   (cutoff_i),
    .sum_o   (sum_o),
    .done_o  (done_o),
    .hit_o   (hit_o)
  );

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> (done_o && hit_o && !busy_o)) else $error("empty run not completed"); // R9
endmodule

// File: tb/tb_fit_score.sv
module tb_fit_score;
  localparam int SW = 8;
  localparam int CW = 16;
  localparam int EW = 8;
  localparam int XW = EW + 1;
  localparam int AW = 2 * SW + 2 + CW + EW + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, mode_i, valid_i;
  logic [SW-1:0] tgt_i, smp_i;
  logic [EW-1:0] npos_i, nneg_i;
  logic [CW-1:0] tpe_i;
  logic [AW-1:0] cutoff_i;
  logic          busy_o, done_o, hit_o;
  logic [XW-1:0] ex_idx_o;
  logic [CW-1:0] tick_idx_o;
  logic [AW-1:0] sum_o;

  int  nchecks = 0;
  int  nerrors = 0;
  bit  finished = 1'b0;

  fit_score dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nchecks++;
    if (act != exp) begin
      nerrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int smp_val(input int k, input int seed);
    if (seed < 0) return -128;
    return ((k * 37 + seed) % 256) - 128;
  endfunction

  // md: 0 constant, 1 classification. hitwant selects threshold = sum or sum-1.
  task automatic run_case(input int md, input int tgt, input int np, input int nn,
                          input int c, input int seed, input bit gaps, input bit hitwant);
    int     total;
    longint exp_sum, part, cut, d, t;
    string  rq;
    total = c * (np + nn);
    rq = (md == 0) ? "R3" : "R4";
    exp_sum = 0;
    for (int k = 0; k < total; k++) begin
      t = (md == 0) ? tgt : (((k / c) < np) ? 51 : -51);
      d = smp_val(k, seed) - t;
      exp_sum += d * d;
    end
    cut = hitwant ? exp_sum : ((exp_sum == 0) ? 0 : exp_sum - 1);
    @(negedge clk);
    start_i = 1'b1; mode_i = md[0]; tgt_i = SW'(tgt);
    npos_i = EW'(np); nneg_i = EW'(nn); tpe_i = CW'(c); cutoff_i = AW'(cut);
    valid_i = 1'b1; smp_i = 8'h7f;
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
    if (total == 0) begin
      chk("R9 done", done_o, 1); chk("R9 sum", sum_o, 0);
      chk("R9 hit", hit_o, 1);   chk("R9 busy", busy_o, 0);
      @(negedge clk);
      chk("R6 done low", done_o, 0);
      return;
    end
    chk("R2 busy", busy_o, 1); chk("R2 sum", sum_o, 0); chk("R2 hit", hit_o, 0);
    part = 0;
    for (int k = 0; k < total; k++) begin
      if (gaps && (k % 3 == 1)) begin
        valid_i = 1'b0; smp_i = 8'h80;
        @(negedge clk);
        chk("R8 gap sum", sum_o, part);
      end
      chk("R5 ex", ex_idx_o, k / c);
      chk("R5 tick", tick_idx_o, k % c);
      valid_i = 1'b1; smp_i = SW'(smp_val(k, seed));
      t = (md == 0) ? tgt : (((k / c) < np) ? 51 : -51);
      d = smp_val(k, seed) - t;
      part += d * d;
      @(negedge clk);
      valid_i = 1'b0;
      if (k != total - 1) chk({rq, " partial"}, sum_o, part);
    end
    chk("R6 done", done_o, 1); chk({rq, " sum"}, sum_o, exp_sum);
    chk("R7 hit", hit_o, (exp_sum <= cut) ? 1 : 0);
    chk("R6 busy", busy_o, 0); chk("R6 ex", ex_idx_o, 0); chk("R6 tick", tick_idx_o, 0);
    valid_i = 1'b1; smp_i = 8'h80;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R6 done low", done_o, 0);
    chk("R7 hit held", hit_o, (exp_sum <= cut) ? 1 : 0);
    @(negedge clk);
    chk("R8 idle sum", sum_o, exp_sum);
    chk("R8 idle tick", tick_idx_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; valid_i = 1'b0;
    tgt_i = '0; smp_i = '0; npos_i = '0; nneg_i = '0; tpe_i = '0; cutoff_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 sum", sum_o, 0); chk("R1 done", done_o, 0); chk("R1 hit", hit_o, 0);
    chk("R1 busy", busy_o, 0); chk("R1 ex", ex_idx_o, 0); chk("R1 tick", tick_idx_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 default constant task: target 0.5625 over 15 ticks
    run_case(0, 36, 1, 0, 15, 5, 1'b1, 1'b1);
    // R3 every sample value once against constant target
    run_case(0, 36, 1, 0, 256, 0, 1'b0, 1'b0);
    run_case(0, -20, 2, 1, 4, 9, 1'b1, 1'b1);
    // R4 R5 R9 classification sweep
    for (int np = 0; np < 4; np++)
      for (int nn = 0; nn < 4; nn++)
        for (int c = 1; c < 4; c++)
          run_case(1, 0, np, nn, c, np * 16 + nn * 4 + c, (c == 2), ((np + nn + c) % 2 == 0));
    // R9 zero ticks per example
    run_case(1, 0, 3, 2, 0, 1, 1'b0, 1'b1);
    // R11 restart mid-run
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b0; tgt_i = 8'd100; npos_i = 8'd1; nneg_i = 8'd0;
    tpe_i = 16'd10; cutoff_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      valid_i = 1'b1; smp_i = 8'h80;
      @(negedge clk);
    end
    valid_i = 1'b0;
    run_case(0, 10, 1, 0, 3, 4, 1'b0, 1'b1);
    chk("R11 restart", sum_o, 64'(((4-128-10)*(4-128-10)) + ((41-128-10)*(41-128-10))
                                   + ((78-128-10)*(78-128-10))));
    // R10 longest run at worst-case error
    run_case(0, 127, 1, 0, 65535, -1, 1'b0, 1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchecks++;
      nerrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end
endmodule